// File: doc/BRIEF.md
# Sensor Count to Engineering Unit Converter

This block takes one raw sample word from an on-die sensor and turns its count into a signed engineering value. It has two modes. In temperature mode the result is in millidegrees Celsius. It is built from four programmable coefficients and the sensor clock frequency, and it is clamped to the operating range. In voltage mode the result is a linear function of the count, with a per-request gain of one or two applied before the final scaling.

A request is offered with `inValid`. It is accepted on a clock edge where `inReady` is high. All operands are sampled at that edge. One sequential restoring divider, shared by both modes, performs every division. Voltage mode needs one division and temperature mode needs two. Only one conversion is in flight at a time. The result is presented on `outResult`, qualified by a single-cycle `outValid` pulse.

Top module: `conv_top`

## Requirements
- R1: Only bits [15:0] of `inSample` form the unsigned count n. Bits [31:16] have no effect on the result.
- R2: With `inVolt`=0, the result is G + trunc(H·n / cal5) − trunc(H/2) + trunc(J·F / 1000000). F is `coefFreq` in Hz, J is signed, H and cal5 are unsigned, and every division truncates toward zero.
- R3: The temperature result is limited to the range −40000 to 125000. A value below that range gives −40000 and a value above it gives 125000.
- R4: With `inVolt`=1, the result is trunc(p·(90·n − 245805) / 1024). p is 2 when `inX2`=1 and 1 otherwise. The gain is applied before the division.
- R5: The voltage division truncates toward zero for negative values. For example, n=0 gives −240 with p=1 and −480 with p=2, not −241 and −481.
- R6: `inReady` goes low on the edge after acceptance and stays low until the cycle in which `outValid` is high. `inValid` is ignored while `inReady` is low.
- R7: `outValid` rises a fixed number of edges after the acceptance edge and lasts exactly one cycle. This is DIV_W+2 edges in voltage mode and 2·DIV_W+3 in temperature mode, which is 50 and 99 for DIV_W=48.
- R8: While reset is active and just after it, `inReady`=1, `outValid`=0 and `outResult`=0.
- R9: Operands and mode are captured at acceptance. Changing any input while a conversion is in flight does not alter its result.
- R10: `outResult` holds its value between `outValid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request offered |
| inReady | output | 1 | Block can accept a request |
| inSample | input | 32 | Sample word; low 16 bits are the count |
| inVolt | input | 1 | 1 = voltage mode, 0 = temperature mode |
| inX2 | input | 1 | Voltage gain select, 1 = twice |
| coefG | input | 24 | Temperature offset G, signed |
| coefH | input | 24 | Temperature slope H, unsigned |
| coefCal5 | input | 24 | Count normaliser cal5, unsigned |
| coefJ | input | 16 | Frequency coefficient J, signed |
| coefFreq | input | 32 | Sensor clock frequency in Hz |
| outValid | output | 1 | One-cycle result strobe |
| outResult | output | 32 | Signed converted value |

## Verification
A voltage result is due DIV_W+2 edges after the acceptance edge, and a temperature result is due 2·DIV_W+3 edges after it. The bench drives on falling edges and counts rising edges from acceptance, sampling `outValid` at the following falling edge. It flags a result that arrives early or late, as well as a wrong value. While waiting, it checks that `inReady` stays low. It then disturbs every input for a few cycles, which shows that late stimulus neither starts a second conversion nor changes the result already in flight.

// File: rtl/conv_pkg.sv
package conv_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch operands
    logic startA;    // launch first division
    logic startB;    // launch second division (temperature only)
    logic finVolt;   // register voltage result
    logic finTemp;   // register clamped temperature result
  } convCtrl_t;

  localparam int TEMP_LO     = -40000;
  localparam int TEMP_HI     = 125000;
  localparam int VOLT_SLOPE  = 90;
  localparam int VOLT_OFFSET = 245805;
  localparam int VOLT_DIV    = 1024;
  localparam int FREQ_DIV    = 1000000;
endpackage

// File: rtl/conv_div.sv
module conv_div #(
  parameter int W = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic signed [W-1:0] dividend,
  input  logic signed [W-1:0] divisor,
  output logic                done,
  output logic signed [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem, quo, dvs;
  logic [CW-1:0] cnt;
  logic          busy, negQ;
  logic [W:0]    trial;

  assign trial = {rem, quo[W-1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rem <= '0; quo <= '0; dvs <= '0; cnt <= '0;
      busy <= 1'b0; negQ <= 1'b0; done <= 1'b0;
    end else if (start) begin
      rem  <= '0;
      quo  <= dividend[W-1] ? -dividend : dividend;
      dvs  <= divisor[W-1]  ? -divisor  : divisor;
      negQ <= dividend[W-1] ^ divisor[W-1];
      cnt  <= CW'(W);
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy) begin
      if (trial >= {1'b0, dvs}) begin
        rem <= W'(trial - {1'b0, dvs});
        quo <= {quo[W-2:0], 1'b1};
      end else begin
        rem <= trial[W-1:0];
        quo <= {quo[W-2:0], 1'b0};
      end
      cnt  <= cnt - 1'b1;
      busy <= (cnt != CW'(1));
      done <= (cnt == CW'(1));
    end else begin
      done <= 1'b0;
    end
  end

  assign quotient = negQ ? -$signed(quo) : $signed(quo);
endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import conv_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      isVolt,
  input  logic      divDone,
  output logic      inReady,
  output logic      outValid,
  output convCtrl_t ctrl
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_DIVA, S_DIVB} state_t;
  state_t state, stateNxt;

  always_comb begin
    ctrl     = '0;
    stateNxt = state;
    case (state)
      S_IDLE: if (inValid) begin ctrl.capture = 1'b1; stateNxt = S_LOAD; end
      S_LOAD: begin ctrl.startA = 1'b1; stateNxt = S_DIVA; end
      S_DIVA: if (divDone) begin
        if (isVolt) begin ctrl.finVolt = 1'b1; stateNxt = S_IDLE; end
        else begin ctrl.startB = 1'b1; stateNxt = S_DIVB; end
      end
      S_DIVB: if (divDone) begin ctrl.finTemp = 1'b1; stateNxt = S_IDLE; end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      outValid <= 1'b0;
    end else begin
      state    <= stateNxt;
      outValid <= ctrl.finVolt | ctrl.finTemp;
    end
  end

  assign inReady = (state == S_IDLE);
endmodule

// File: rtl/conv_dp.sv
module conv_dp
  import conv_pkg::*;
#(
  parameter int COEF_W = 24,
  parameter int J_W    = 16,
  parameter int FREQ_W = 32,
  parameter int DIV_W  = 48,
  parameter int RES_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  convCtrl_t               ctrl,
  input  logic [15:0]             inCount,
  input  logic                    inVolt,
  input  logic                    inX2,
  input  logic signed [COEF_W-1:0] coefG,
  input  logic [COEF_W-1:0]       coefH,
  input  logic [COEF_W-1:0]       coefCal5,
  input  logic signed [J_W-1:0]   coefJ,
  input  logic [FREQ_W-1:0]       coefFreq,
  input  logic signed [DIV_W-1:0] quot,
  output logic signed [DIV_W-1:0] divDividend,
  output logic signed [DIV_W-1:0] divDivisor,
  output logic                    isVolt,
  output logic signed [RES_W-1:0] outResult
);
  localparam logic signed [DIV_W-1:0] LO   = DIV_W'(TEMP_LO);
  localparam logic signed [DIV_W-1:0] HI   = DIV_W'(TEMP_HI);
  localparam logic signed [DIV_W-1:0] SLP  = DIV_W'(VOLT_SLOPE);
  localparam logic signed [DIV_W-1:0] OFS  = DIV_W'(VOLT_OFFSET);
  localparam logic signed [DIV_W-1:0] VDIV = DIV_W'(VOLT_DIV);
  localparam logic signed [DIV_W-1:0] FDIV = DIV_W'(FREQ_DIV);

  logic [15:0]              nReg;
  logic                     x2Reg;
  logic signed [DIV_W-1:0]  gExt, hExt, cExt, jExt, fExt, nExt, quotA;
  logic signed [DIV_W-1:0]  prodHN, prodJF, vBase, vScaled, sumT, sumClamp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nReg <= '0; x2Reg <= 1'b0; isVolt <= 1'b0;
      gExt <= '0; hExt <= '0; cExt <= '0; jExt <= '0; fExt <= '0;
      quotA <= '0; outResult <= '0;
    end else begin
      if (ctrl.capture) begin
        nReg   <= inCount;
        x2Reg  <= inX2;
        isVolt <= inVolt;
        gExt   <= DIV_W'(coefG);
        hExt   <= $signed({{(DIV_W-COEF_W){1'b0}}, coefH});
        cExt   <= $signed({{(DIV_W-COEF_W){1'b0}}, coefCal5});
        jExt   <= DIV_W'(coefJ);
        fExt   <= $signed({{(DIV_W-FREQ_W){1'b0}}, coefFreq});
      end
      if (ctrl.startB)  quotA     <= quot;
      if (ctrl.finVolt) outResult <= quot[RES_W-1:0];
      if (ctrl.finTemp) outResult <= sumClamp[RES_W-1:0];
    end
  end

  assign nExt    = $signed({{(DIV_W-16){1'b0}}, nReg});
  assign prodHN  = hExt * nExt;
  assign prodJF  = jExt * fExt;
  assign vBase   = nExt * SLP - OFS;
  assign vScaled = x2Reg ? (vBase <<< 1) : vBase;

  always_comb begin
    if (ctrl.startB) begin
      divDividend = prodJF;
      divDivisor  = FDIV;
    end else if (isVolt) begin
      divDividend = vScaled;
      divDivisor  = VDIV;
    end else begin
      divDividend = prodHN;
      divDivisor  = cExt;
    end
  end

  assign sumT = gExt + quotA - (hExt >>> 1) + quot;

  always_comb begin
    if (sumT < LO)      sumClamp = LO;
    else if (sumT > HI) sumClamp = HI;
    else                sumClamp = sumT;
  end
endmodule

// File: rtl/conv_top.sv
module conv_top
  import conv_pkg::*;
#(
  parameter int COEF_W = 24,
  parameter int J_W    = 16,
  parameter int FREQ_W = 32,
  parameter int DIV_W  = 48,
  parameter int RES_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [31:0]              inSample,
  input  logic                     inVolt,
  input  logic                     inX2,
  input  logic signed [COEF_W-1:0] coefG,
  input  logic [COEF_W-1:0]        coefH,
  input  logic [COEF_W-1:0]        coefCal5,
  input  logic signed [J_W-1:0]    coefJ,
  input  logic [FREQ_W-1:0]        coefFreq,
  output logic                     outValid,
  output logic signed [RES_W-1:0]  outResult
);
  convCtrl_t               ctrl;
  logic                    divDone, isVolt;
  logic signed [DIV_W-1:0] divDividend, divDivisor, quot;

  conv_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isVolt(isVolt),
    .divDone(divDone), .inReady(inReady), .outValid(outValid), .ctrl(ctrl)
  );

  conv_dp #(.COEF_W(COEF_W), .J_W(J_W), .FREQ_W(FREQ_W), .DIV_W(DIV_W), .RES_W(RES_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inCount(inSample[15:0]),
    .inVolt(inVolt), .inX2(inX2), .coefG(coefG), .coefH(coefH),
    .coefCal5(coefCal5), .coefJ(coefJ), .coefFreq(coefFreq), .quot(quot),
    .divDividend(divDividend), .divDivisor(divDivisor), .isVolt(isVolt),
    .outResult(outResult)
  );

  conv_div #(.W(DIV_W)) uDiv (
    .clk(clk), .rstN(rstN), .start(ctrl.startA | ctrl.startB),
    .dividend(divDividend), .divisor(divDivisor), .done(divDone), .quotient(quot)
  );
endmodule

// File: rtl/conv_top_chk.sv
module conv_top_chk #(
  parameter int DIV_W = 48,
  parameter int RES_W = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    inReady,
  input logic                    inVolt,
  input logic                    outValid,
  input logic signed [RES_W-1:0] outResult
);
  localparam int LAT_V = DIV_W + 2;
  localparam int LAT_T = 2 * DIV_W + 3;
  localparam int CW    = $clog2(LAT_T + 2) + 1;

  logic          busyC, modeC;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyC <= 1'b0; modeC <= 1'b0; cnt <= '0;
    end else if (inValid && inReady) begin
      busyC <= 1'b1; modeC <= inVolt; cnt <= '0;
    end else if (outValid) begin
      busyC <= 1'b0;
    end else if (busyC) begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);
  a_r6_ready_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inReady);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
  a_r7_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (busyC && (cnt == (modeC ? CW'(LAT_V) : CW'(LAT_T)))));
  a_r3_clamp_range: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !modeC) |-> (outResult >= -40000 && outResult <= 125000));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |=> (outValid || $stable(outResult)));
endmodule

bind conv_top conv_top_chk #(.DIV_W(DIV_W), .RES_W(RES_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inVolt(inVolt), .outValid(outValid), .outResult(outResult)
);

// File: tb/tb_conv_top.sv
module tb_conv_top;
  localparam int DIV_W = 48;
  localparam int LAT_V = DIV_W + 2;
  localparam int LAT_T = 2 * DIV_W + 3;
  localparam logic [31:0] SAMPLES [4] = '{32'h0000_0000, 32'h5A00_07FF, 32'hABCD_0FFF, 32'hFFFF_FFFF};

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, inVolt = 1'b0, inX2 = 1'b0;
  logic inReady, outValid;
  logic [31:0] inSample = '0;
  logic signed [23:0] coefG = '0;
  logic [23:0] coefH = '0, coefCal5 = 24'd1;
  logic signed [15:0] coefJ = '0;
  logic [31:0] coefFreq = '0;
  logic signed [31:0] outResult;
  int total = 0, bad = 0;
  bit watchdogHit = 0;

  always #2.5 clk = ~clk;

  conv_top dut (.*);

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint refTemp(longint g, longint h, longint c, longint j, longint f, longint n);
    longint t;
    t = g + (h * n) / c - h / 2 + (j * f) / 1000000;
    if (t < -40000) t = -40000;
    if (t > 125000) t = 125000;
    return t;
  endfunction

  function automatic longint refVolt(longint p, longint n);
    return (p * (90 * n - 245805)) / 1024;
  endfunction

  task automatic setCoef(input int setB);
    coefG    = setB ? 24'sd57400 : 24'sd60000;
    coefH    = setB ? 24'd249400 : 24'd200000;
    coefCal5 = setB ? 24'd4096 : 24'd4094;
    coefJ    = setB ? 16'sd0 : -16'sd100;
    coefFreq = 32'd100_000_000;
  endtask

  // one conversion; returns result, checks latency (R7) and busy behaviour (R6, R9)
  task automatic convert(input logic [31:0] smp, input logic volt, input logic x2, output longint res);
    int k;
    logic [23:0] sg, sh, sc; logic [15:0] sj; logic [31:0] sf;
    @(negedge clk);
    inSample = smp; inVolt = volt; inX2 = x2; inValid = 1'b1;
    sg = coefG; sh = coefH; sc = coefCal5; sj = coefJ; sf = coefFreq;
    @(posedge clk);
    @(negedge clk);
    // R9: disturb every input while busy, then restore
    inValid = 1'b1; inSample = ~smp; inVolt = ~volt; inX2 = ~x2;
    coefG = 24'sd1; coefH = 24'd7; coefCal5 = 24'd3; coefJ = 16'sd5; coefFreq = 32'd9;
    k = 0;
    while (1) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (k == 3) begin
        inValid = 1'b0; inSample = smp; inVolt = volt; inX2 = x2;
        coefG = sg; coefH = sh; coefCal5 = sc; coefJ = sj; coefFreq = sf;
      end
      if (outValid || k > LAT_T + 5) break;
      if (inReady !== 1'b0) begin check("R6 ready low while busy", inReady, 0); break; end
    end
    check("R7 latency", k, volt ? LAT_V : LAT_T);
    check("R6 ready with valid", inReady, 1);
    res = outResult;
    @(posedge clk); @(negedge clk);
    check("R7 one-cycle valid", outValid, 0);
    check("R10 result held", outResult, res);
  endtask

  initial begin
    #1_000_000;
    watchdogHit = 1;
  end

  initial begin
    longint r, e;
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 ready in reset", inReady, 1);
        check("R8 valid in reset", outValid, 0);
        check("R8 result in reset", outResult, 0);
        rstN = 1'b1;
        @(negedge clk);
        check("R8 valid after reset", outValid, 0);

        // table walk: 4 configurations x 4 samples (R1 upper bits set in some, R2/R4)
        for (int cfg = 0; cfg < 4; cfg++) begin
          for (int i = 0; i < 4; i++) begin
            longint n;
            n = longint'(SAMPLES[i][15:0]);
            setCoef(cfg == 1);
            convert(SAMPLES[i], cfg >= 2, cfg == 3, r);
            if (cfg < 2)
              e = refTemp(longint'(coefG), longint'(coefH), longint'(coefCal5),
                          longint'(coefJ), longint'(coefFreq), n);
            else
              e = refVolt((cfg == 3) ? 2 : 1, n);
            check(cfg < 2 ? "R2 temperature value (R1 low bits)" : "R4 voltage value (R1 low bits)", r, e);
          end
        end

        // R5 explicit truncation toward zero
        convert(32'h0, 1'b1, 1'b0, r); check("R5 n=0 x1", r, -240);
        convert(32'h0, 1'b1, 1'b1, r); check("R5 n=0 x2", r, -480);
        // R3 clamp bounds with set A
        setCoef(0);
        convert(32'h0, 1'b0, 1'b0, r);  check("R3 low clamp", r, -40000);
        convert(32'hFFFF, 1'b0, 1'b0, r); check("R3 high clamp", r, 125000);
        // R1 upper bits only differ
        setCoef(1);
        convert(32'h0000_07FF, 1'b0, 1'b0, e);
        convert(32'hFFFF_07FF, 1'b0, 1'b0, r); check("R1 upper bits ignored", r, e);
        // R2 in-range value with set B, n=2047: 57400+124639-124700
        check("R2 set B n=2047", r, 57339);
      end
      begin
        wait (watchdogHit);
      end
    join_any
    if (watchdogHit) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule